// File: doc/BRIEF.md
# Mode Register Command Decoder

This block watches the command pins of a synchronous graphics memory on every rising clock edge. When chip select, row strobe, column strobe and write enable are all low while clock enable is high, the cycle is a mode write. Bank bit 0 then picks the target: low writes the standard configuration register, high writes the extended one. The address and bank pins of that cycle are checked, and if they are legal they are stored.

The decoded configuration is presented as plain control outputs: burst length, burst ordering, read latency, test mode, DLL enable and output drive strength. A DLL reset request appears as a single-cycle pulse and is not stored. A write is refused, with the stored contents left as they were, if it carries a reserved code or a nonzero reserved bit. It is also refused if some bank is still open, or if it falls inside the two-clock completion window of the previous accepted write. Every refusal sets a sticky error flag. All outputs are registered and change right after the sampling edge.

Top module: `modereg_ctl`

## Requirements
- R1: After reset: burst_len 2, burst_interleave 0, read_lat 3, test_mode 0, dll_enable 1, drive_strength 00, dll_reset_pulse 0, mode_error 0, mrs_busy 0.
- R2: A mode write is taken only on an edge with cke=1, cs_n=0, ras_n=0, cas_n=0 and we_n=0. With cs_n high, cke low, or any strobe high, the stored configuration is unchanged and no error is raised.
- R3: With ba[0]=0 an accepted write loads the standard fields. addr[2:0] sets the burst length (001=2, 010=4, 011=8). addr[3] sets the order (0 sequential, 1 interleaved). addr[6:4] sets the read latency (011=3, 100=4). addr[7] sets test mode.
- R4: A standard write with a reserved burst code, a reserved latency code, ba[1]=1, or any of addr[11:9] set is refused. mode_error is set and every field keeps its value.
- R5: With ba[0]=1 an accepted write loads the extended fields. addr[0]=0 gives dll_enable=1 and addr[0]=1 gives dll_enable=0. The code {addr[6],addr[1]} selects drive_strength: 00 normal, 01 weak, 11 matched.
- R6: An extended write with drive code 10, ba[1]=1, or any of addr[2..5] or addr[7..11] set is refused. mode_error is set and every field keeps its value.
- R7: An accepted standard write with addr[8]=1 raises dll_reset_pulse for exactly the one cycle after the sampling edge. A refused write never raises it.
- R8: A mode write while all_banks_idle=0 is refused and sets mode_error.
- R9: After an accepted write, mrs_busy is high for one cycle. A mode write on the next edge is refused and sets mode_error. A write two edges later is accepted.
- R10: mode_error stays set until reset, and later legal writes still update the fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples commands |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, high to accept commands |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank bits; bit 0 picks the register, bit 1 must be 0 |
| addr | input | ADDR_W (12) | Address pins carrying the field values |
| all_banks_idle | input | 1 | High when every bank is precharged |
| burst_len | output | 4 | Burst length in beats (2, 4 or 8) |
| burst_interleave | output | 1 | 1 interleaved, 0 sequential order |
| read_lat | output | 3 | Read latency in clocks (3 or 4) |
| test_mode | output | 1 | Test mode select |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| dll_enable | output | 1 | DLL enabled when high |
| drive_strength | output | 2 | 00 normal, 01 weak, 11 matched |
| mode_error | output | 1 | Sticky flag for refused writes |
| mrs_busy | output | 1 | Completion window of the last accepted write |

## Verification
Two things can happen on the same edge: the DLL reset pulse from an accepted write, and the refusal of a second write that arrives before the completion window has closed. The bench drives a standard write with the reset bit set and a different standard write on the very next edge. It then checks that the pulse and busy flag are high after the first edge. After the second edge it checks that the pulse has dropped, mode_error is set, and the fields still hold the first write's values. A write spaced one idle cycle later is checked to be accepted.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int BL_LSB    = 0;
  localparam int BT_BIT    = 3;
  localparam int LAT_LSB   = 4;
  localparam int TM_BIT    = 7;
  localparam int DLLR_BIT  = 8;
  localparam int DLLD_BIT  = 0;
  localparam int DS_LO_BIT = 1;
  localparam int DS_HI_BIT = 6;

  typedef enum logic [1:0] {
    DRV_NORMAL  = 2'b00,
    DRV_WEAK    = 2'b01,
    DRV_MATCHED = 2'b11
  } drv_t;

  function automatic logic bl_code_ok(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd3);
  endfunction

  function automatic logic [3:0] bl_beats(input logic [2:0] c);
    case (c)
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic lat_code_ok(input logic [2:0] c);
    return (c == 3'd3) || (c == 3'd4);
  endfunction
endpackage

// File: rtl/mrc_cmd_decode.sv
module mrc_cmd_decode (
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic sel_ext,
  output logic std_wr,
  output logic ext_wr
);
  logic mode_cmd;
  always_comb begin
    mode_cmd = cke && !cs_n && !ras_n && !cas_n && !we_n;
    std_wr   = mode_cmd && !sel_ext;
    ext_wr   = mode_cmd &&  sel_ext;
  end
endmodule

// File: rtl/mrc_window.sv
module mrc_window #(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CW'(GAP_CYCLES - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  generate
    if (GAP_CYCLES > 1) begin : g_chk
      AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R9
    end
  endgenerate
endmodule

// File: rtl/mrc_std_reg.sv
module mrc_std_reg
  import mrc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              allowed,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ba_hi,
  output logic              accept,
  output logic              bad,
  output logic [3:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        read_lat,
  output logic              test_mode,
  output logic              dll_reset_pulse
);
  localparam int RSV_LSB = DLLR_BIT + 1;

  logic [2:0] bl_code, lat_code;
  logic       rsv_set, legal;

  always_comb begin
    bl_code  = addr[BL_LSB +: 3];
    lat_code = addr[LAT_LSB +: 3];
    rsv_set  = ba_hi || ((addr >> RSV_LSB) != '0);
    legal    = bl_code_ok(bl_code) && lat_code_ok(lat_code) && !rsv_set;
    accept   = wr && allowed && legal;
    bad      = wr && !(allowed && legal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_len        <= 4'd2;
      burst_interleave <= 1'b0;
      read_lat         <= 3'd3;
      test_mode        <= 1'b0;
      dll_reset_pulse  <= 1'b0;
    end else begin
      dll_reset_pulse <= accept && addr[DLLR_BIT];
      if (accept) begin
        burst_len        <= bl_beats(bl_code);
        burst_interleave <= addr[BT_BIT];
        read_lat         <= lat_code;
        test_mode        <= addr[TM_BIT];
      end
    end
  end

  AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (read_lat == 3'd3) || (read_lat == 3'd4)); // R4
  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(burst_len) && (burst_len >= 4'd2)); // R4
  AST_STD_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> $stable({burst_len, burst_interleave, read_lat, test_mode}) && !dll_reset_pulse); // R4
endmodule

// File: rtl/mrc_ext_reg.sv
module mrc_ext_reg
  import mrc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              allowed,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ba_hi,
  output logic              accept,
  output logic              bad,
  output logic              dll_enable,
  output logic [1:0]        drive_strength
);
  localparam logic [ADDR_W-1:0] USED_MASK =
    ADDR_W'((1 << DLLD_BIT) | (1 << DS_LO_BIT) | (1 << DS_HI_BIT));

  logic [1:0] ds_code;
  logic       legal;

  always_comb begin
    ds_code = {addr[DS_HI_BIT], addr[DS_LO_BIT]};
    legal   = !ba_hi && ((addr & ~USED_MASK) == '0) && (ds_code != 2'b10);
    accept  = wr && allowed && legal;
    bad     = wr && !(allowed && legal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_enable     <= 1'b1;
      drive_strength <= DRV_NORMAL;
    end else if (accept) begin
      dll_enable     <= !addr[DLLD_BIT];
      drive_strength <= ds_code;
    end
  end

  AST_DS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    drive_strength != 2'b10); // R6
  AST_EXT_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> $stable({dll_enable, drive_strength})); // R6
endmodule

// File: rtl/modereg_ctl.sv
module modereg_ctl #(
  parameter int ADDR_W     = 12,
  parameter int GAP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              all_banks_idle,
  output logic [3:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        read_lat,
  output logic              test_mode,
  output logic              dll_reset_pulse,
  output logic              dll_enable,
  output logic [1:0]        drive_strength,
  output logic              mode_error,
  output logic              mrs_busy
);
  logic std_wr, ext_wr, allowed;
  logic std_acc, std_bad, ext_acc, ext_bad;

  mrc_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .sel_ext(ba[0]), .std_wr(std_wr), .ext_wr(ext_wr)
  );

  assign allowed = all_banks_idle && !mrs_busy;

  mrc_std_reg #(.ADDR_W(ADDR_W)) u_std (
    .clk(clk), .rst_n(rst_n), .wr(std_wr), .allowed(allowed), .addr(addr),
    .ba_hi(ba[1]), .accept(std_acc), .bad(std_bad),
    .burst_len(burst_len), .burst_interleave(burst_interleave),
    .read_lat(read_lat), .test_mode(test_mode), .dll_reset_pulse(dll_reset_pulse)
  );

  mrc_ext_reg #(.ADDR_W(ADDR_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .wr(ext_wr), .allowed(allowed), .addr(addr),
    .ba_hi(ba[1]), .accept(ext_acc), .bad(ext_bad),
    .dll_enable(dll_enable), .drive_strength(drive_strength)
  );

  mrc_window #(.GAP_CYCLES(GAP_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .start(std_acc || ext_acc), .busy(mrs_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mode_error <= 1'b0;
    else if (std_bad || ext_bad) mode_error <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_error |=> mode_error); // R10
  AST_NO_CMD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |=> $stable({burst_len, burst_interleave, read_lat, test_mode,
                                dll_enable, drive_strength, mode_error})); // R2
  AST_BANKS_OPEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (std_wr || ext_wr) && !all_banks_idle |=> mode_error); // R8
  AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (std_wr || ext_wr) && mrs_busy |=> mode_error && !dll_reset_pulse); // R9

  generate
    if (GAP_CYCLES > 1) begin : g_pulse
      AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset_pulse |=> !dll_reset_pulse); // R7
    end
  endgenerate
endmodule

// File: tb/modereg_ctl_bench.sv
`timescale 1ns/1ps
module modereg_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic all_banks_idle = 1'b1;
  logic [3:0] burst_len;
  logic burst_interleave, test_mode, dll_reset_pulse, dll_enable, mode_error, mrs_busy;
  logic [2:0] read_lat;
  logic [1:0] drive_strength;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  modereg_ctl u_modereg_ctl (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .all_banks_idle(all_banks_idle), .burst_len(burst_len),
    .burst_interleave(burst_interleave), .read_lat(read_lat),
    .test_mode(test_mode), .dll_reset_pulse(dll_reset_pulse),
    .dll_enable(dll_enable), .drive_strength(drive_strength),
    .mode_error(mode_error), .mrs_busy(mrs_busy)
  );

  typedef struct packed {
    logic [1:0]  b;
    logic [11:0] a;
    logic [3:0]  bl;
    logic        bt;
    logic [2:0]  lat;
    logic        tm;
    logic        den;
    logic [1:0]  ds;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 12'h032, 4'd4, 1'b0, 3'd3, 1'b0, 1'b1, 2'b00},
    '{2'b00, 12'h04B, 4'd8, 1'b1, 3'd4, 1'b0, 1'b1, 2'b00},
    '{2'b00, 12'h0C1, 4'd2, 1'b0, 3'd4, 1'b1, 1'b1, 2'b00},
    '{2'b01, 12'h003, 4'd2, 1'b0, 3'd4, 1'b1, 1'b0, 2'b01},
    '{2'b01, 12'h042, 4'd2, 1'b0, 3'd4, 1'b1, 1'b1, 2'b11},
    '{2'b01, 12'h001, 4'd2, 1'b0, 3'd4, 1'b1, 1'b0, 2'b00},
    '{2'b00, 12'h03A, 4'd4, 1'b1, 3'd3, 1'b0, 1'b0, 2'b00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nop_pins();
    cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; nop_pins(); all_banks_idle = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one command for one edge; return at the negedge after it
  task automatic cmd(input logic k, input logic c, input logic r, input logic s,
                     input logic w, input logic [1:0] b, input logic [11:0] a);
    @(negedge clk);
    cke = k; cs_n = c; ras_n = r; cas_n = s; we_n = w; ba = b; addr = a;
    @(negedge clk);
    nop_pins();
  endtask

  task automatic mrs(input logic [1:0] b, input logic [11:0] a);
    cmd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, b, a);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 burst_len", burst_len, 2);
    chk("R1 interleave", burst_interleave, 0);
    chk("R1 read_lat", read_lat, 3);
    chk("R1 test_mode", test_mode, 0);
    chk("R1 dll_enable", dll_enable, 1);
    chk("R1 drive", drive_strength, 0);
    chk("R1 pulse", dll_reset_pulse, 0);
    chk("R1 error", mode_error, 0);
    chk("R1 busy", mrs_busy, 0);

    // R3 R5 table of legal writes
    for (int i = 0; i < NV; i++) begin
      mrs(VECS[i].b, VECS[i].a);
      settle();
      chk("R3 burst_len", burst_len, VECS[i].bl);
      chk("R3 interleave", burst_interleave, VECS[i].bt);
      chk("R3 read_lat", read_lat, VECS[i].lat);
      chk("R3 test_mode", test_mode, VECS[i].tm);
      chk("R5 dll_enable", dll_enable, VECS[i].den);
      chk("R5 drive", drive_strength, VECS[i].ds);
      chk("R3 no error", mode_error, 0);
    end

    // R2 non-mode cycles leave state alone
    do_reset();
    cmd(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 12'h04B); settle();
    chk("R2 cs high", burst_len, 2);
    cmd(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 12'h04B); settle();
    chk("R2 cke low", burst_len, 2);
    cmd(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 12'h04B); settle();
    chk("R2 ras high", burst_len, 2);
    chk("R2 no error", mode_error, 0);

    // R4 reserved standard codes
    do_reset(); mrs(2'b00, 12'h032); settle();
    mrs(2'b00, 12'h030); settle();
    chk("R4 bl reserved err", mode_error, 1);
    chk("R4 bl kept", burst_len, 4);
    do_reset(); mrs(2'b00, 12'h022); settle();
    chk("R4 lat reserved err", mode_error, 1);
    chk("R4 lat kept", read_lat, 3);
    chk("R4 bl kept2", burst_len, 2);
    do_reset(); mrs(2'b10, 12'h032); settle();
    chk("R4 ba1 err", mode_error, 1);
    chk("R4 ba1 kept", burst_len, 2);
    do_reset(); mrs(2'b00, 12'h232); settle();
    chk("R4 rsv bit err", mode_error, 1);
    chk("R4 rsv bit kept", burst_len, 2);

    // R6 reserved extended codes
    do_reset(); mrs(2'b01, 12'h003); settle();
    mrs(2'b01, 12'h040); settle();
    chk("R6 ds 10 err", mode_error, 1);
    chk("R6 ds kept", drive_strength, 1);
    chk("R6 den kept", dll_enable, 0);
    do_reset(); mrs(2'b01, 12'h011); settle();
    chk("R6 bit4 err", mode_error, 1);
    chk("R6 bit4 den kept", dll_enable, 1);

    // R7 DLL reset pulse
    do_reset(); mrs(2'b00, 12'h132);
    chk("R7 pulse high", dll_reset_pulse, 1);
    @(negedge clk);
    chk("R7 pulse one cycle", dll_reset_pulse, 0);
    chk("R7 fields", burst_len, 4);
    settle();
    mrs(2'b00, 12'h130);
    chk("R7 no pulse on refusal", dll_reset_pulse, 0);

    // R8 banks open
    do_reset(); all_banks_idle = 1'b0;
    mrs(2'b00, 12'h04B); all_banks_idle = 1'b1; settle();
    chk("R8 err", mode_error, 1);
    chk("R8 kept", burst_len, 2);

    // R9 back-to-back write while pulse is high
    do_reset();
    @(negedge clk);
    cke = 1'b1; cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
    ba = 2'b00; addr = 12'h132;
    @(negedge clk);
    chk("R9 busy", mrs_busy, 1);
    chk("R7 pulse with busy", dll_reset_pulse, 1);
    addr = 12'h04B;
    @(negedge clk);
    nop_pins();
    chk("R9 second refused err", mode_error, 1);
    chk("R9 first kept", burst_len, 4);
    chk("R7 pulse dropped", dll_reset_pulse, 0);
    // spaced write accepted
    do_reset(); mrs(2'b00, 12'h032);
    mrs(2'b00, 12'h04B); settle();
    chk("R9 spaced accepted", burst_len, 8);
    chk("R9 spaced no err", mode_error, 0);

    // R10 sticky error
    do_reset(); mrs(2'b00, 12'h030); settle();
    mrs(2'b00, 12'h04B); settle();
    chk("R10 still set", mode_error, 1);
    chk("R10 fields update", burst_len, 8);

    report();
  end
endmodule